// File: doc/BRIEF.md
# Rail-Level Frame Extractor

This block watches one digitized stream of 12-bit samples from a front-end readout chip and finds the frames inside it. A frame starts with a digital header whose levels swing rail to rail. The block turns each sample into a digital level by comparing it with a programmable threshold. While the chip has no frame to send, it emits a single-sample sync pulse every 35 sample periods. The block uses those pulses to decide whether the link is alive.

Once the link is up, three consecutive high samples mark the start of a header. The block then takes 8 address bits and 1 error bit from the header. The 128 analog samples that follow go out as a packet stream with start and end markers, the channel number and the decoded header fields. Every frame occupies 140 sample periods. One trigger produces six frames, and the block tags each frame with its position inside that group.

Samples arrive at one third of the system clock rate and are marked by a one-clock valid strobe.

Top module: `rail_frame_extractor`

## Requirements
- R1: After reset, `link_up` is 0 and `fo_valid` is 0.
- R2: While unlocked, two rising high samples that are exactly 35 samples apart set `link_up` to 1 in the clock after the second one. Any other spacing leaves `link_up` at 0 and restarts the measurement from the later pulse.
- R3: A sample is high only when it is strictly greater than `level_thresh`. A sample equal to the threshold is low.
- R4: While idle and locked, if 40 samples pass after the last rising sample (or after the end of a frame) with no new rising sample, `link_up` drops to 0. The frame position inside the trigger group restarts at 0.
- R5: While idle and locked, three consecutive high samples start a header. The next 8 samples are the address, most significant bit first, and appear on `fo_addr`. The sample after those is the error bit, and `fo_err` shows its level (high = 1).
- R6: The 128 samples after the header are emitted in arrival order. Each one appears on `fo_data` one clock after its strobe, with `fo_valid` high for that single clock and `fo_chan` counting from 0 to 127.
- R7: `fo_sof` is high only with channel 0 and `fo_eof` is high only with channel 127.
- R8: A new header may begin on the sample directly after channel 127, and that frame is extracted with no idle gap.
- R9: `fo_frame` numbers the frames of a trigger from 0 to 5 and wraps back to 0. `fo_trig_end` is high together with `fo_eof` of frame 5 only.
- R10: While unlocked, no header is recognized and `fo_valid` stays 0.
- R11: Input values present while `smp_valid` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_thresh | input | 12 | High/low decision threshold |
| smp_valid | input | 1 | One-clock strobe that marks a new sample |
| smp_data | input | 12 | Sample value |
| link_up | output | 1 | Sync pulses are being tracked |
| fo_valid | output | 1 | Output sample valid |
| fo_sof | output | 1 | First channel of a frame |
| fo_eof | output | 1 | Last channel of a frame |
| fo_data | output | 12 | Channel sample value |
| fo_chan | output | 7 | Channel number |
| fo_addr | output | 8 | Header address |
| fo_err | output | 1 | Header error bit |
| fo_frame | output | 3 | Frame position inside the trigger group |
| fo_trig_end | output | 1 | Last channel of the last frame of a trigger |

## Verification
The assertions assume that `smp_valid` is a single-clock strobe with idle clocks between strobes. They also assume that the threshold does not change while a frame is in progress. Under those conditions every output beat follows a strobe by exactly one clock. The bench strobes once every three clocks and drives all-ones junk on `smp_data` between strobes. It sets the threshold once, before any sample. It keeps the sample stream lawful, so nothing that is not a header start can produce three highs in a row while idle: sync pulses are one sample wide and the stream sits low otherwise. Frames sent while unlocked use flat low data, so they cannot create a 35-sample rising pattern by accident.

// File: rtl/rail_frame_extractor.sv
module rail_frame_extractor #(
  parameter int SW        = 12,
  parameter int START_LEN = 3,
  parameter int ADDR_BITS = 8,
  parameter int NCH       = 128,
  parameter int SYNC_PER  = 35,
  parameter int TMO       = 40,
  parameter int FPT       = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SW-1:0]                level_thresh,
  input  logic                         smp_valid,
  input  logic [SW-1:0]                smp_data,
  output logic                         link_up,
  output logic                         fo_valid,
  output logic                         fo_sof,
  output logic                         fo_eof,
  output logic [SW-1:0]                fo_data,
  output logic [$clog2(NCH)-1:0]       fo_chan,
  output logic [ADDR_BITS-1:0]         fo_addr,
  output logic                         fo_err,
  output logic [$clog2(FPT)-1:0]       fo_frame,
  output logic                         fo_trig_end
);
  localparam int CW = $clog2(NCH);
  localparam int FW = $clog2(FPT);
  localparam int GW = $clog2(TMO);
  localparam int RW = $clog2(START_LEN + 1);
  localparam int HW = $clog2(ADDR_BITS + 1);

  typedef enum logic [1:0] {S_UNLK, S_IDLE, S_HDR, S_DATA} st_t;

  st_t                  st;
  logic                 prev_hi, seen, err_r;
  logic [GW-1:0]        gap;
  logic [RW-1:0]        run;
  logic [HW-1:0]        hcnt;
  logic [ADDR_BITS-1:0] addr_sr;
  logic [CW-1:0]        ch;
  logic [FW-1:0]        frm;

  wire hi       = smp_data > level_thresh;
  wire rise     = hi && !prev_hi;
  wire gap_max  = gap == GW'(TMO - 1);
  wire ch_last  = ch == CW'(NCH - 1);
  wire frm_last = frm == FW'(FPT - 1);

  assign link_up = st != S_UNLK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_UNLK;
      prev_hi <= 1'b0;
      seen <= 1'b0;
      err_r <= 1'b0;
      gap <= '0;
      run <= '0;
      hcnt <= '0;
      addr_sr <= '0;
      ch <= '0;
      frm <= '0;
      fo_valid <= 1'b0;
      fo_sof <= 1'b0;
      fo_eof <= 1'b0;
      fo_data <= '0;
      fo_chan <= '0;
      fo_addr <= '0;
      fo_err <= 1'b0;
      fo_frame <= '0;
      fo_trig_end <= 1'b0;
    end else begin
      fo_valid <= 1'b0;
      fo_sof <= 1'b0;
      fo_eof <= 1'b0;
      fo_trig_end <= 1'b0;
      if (smp_valid) begin
        prev_hi <= hi;
        case (st)
          S_UNLK: begin
            if (rise) begin
              if (seen && gap == GW'(SYNC_PER - 1)) begin
                st <= S_IDLE;
                run <= RW'(1);
              end
              seen <= 1'b1;
              gap <= '0;
            end else if (!gap_max) begin
              gap <= gap + 1'b1;
            end
          end
          S_IDLE: begin
            if (hi && run == RW'(START_LEN - 1)) begin
              st <= S_HDR;
              hcnt <= '0;
              run <= '0;
            end else begin
              run <= hi ? run + 1'b1 : '0;
              if (rise) begin
                gap <= '0;
              end else if (gap_max) begin
                st <= S_UNLK;
                seen <= 1'b0;
                frm <= '0;
                run <= '0;
              end else begin
                gap <= gap + 1'b1;
              end
            end
          end
          S_HDR: begin
            hcnt <= hcnt + 1'b1;
            if (hcnt == HW'(ADDR_BITS)) begin
              err_r <= hi;
              ch <= '0;
              st <= S_DATA;
            end else begin
              addr_sr <= {addr_sr[ADDR_BITS-2:0], hi};
            end
          end
          default: begin
            fo_valid <= 1'b1;
            fo_data <= smp_data;
            fo_chan <= ch;
            fo_sof <= ch == '0;
            fo_eof <= ch_last;
            fo_addr <= addr_sr;
            fo_err <= err_r;
            fo_frame <= frm;
            fo_trig_end <= ch_last && frm_last;
            ch <= ch + 1'b1;
            if (ch_last) begin
              st <= S_IDLE;
              gap <= '0;
              run <= '0;
              frm <= frm_last ? '0 : frm + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rail_frame_extractor_chk.sv
module rail_frame_extractor_chk #(
  parameter int NCH = 128,
  parameter int FPT = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_valid,
  input logic                   link_up,
  input logic                   fo_valid,
  input logic                   fo_sof,
  input logic                   fo_eof,
  input logic [$clog2(NCH)-1:0] fo_chan,
  input logic [$clog2(FPT)-1:0] fo_frame,
  input logic                   fo_trig_end
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !fo_valid && !link_up);
  p_sof_chan0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && fo_sof |-> fo_chan == '0);
  p_eof_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && fo_eof |-> fo_chan == ($clog2(NCH))'(NCH - 1));
  p_beat_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid |-> $past(smp_valid));
  p_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid |=> !fo_valid);
  p_quiet_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> !fo_valid);
  p_trig_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fo_trig_end |-> fo_valid && fo_eof && fo_frame == ($clog2(FPT))'(FPT - 1));
  p_frame_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fo_frame < ($clog2(FPT))'(FPT));
endmodule

bind rail_frame_extractor rail_frame_extractor_chk #(.NCH(NCH), .FPT(FPT)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .link_up(link_up),
  .fo_valid(fo_valid), .fo_sof(fo_sof), .fo_eof(fo_eof), .fo_chan(fo_chan),
  .fo_frame(fo_frame), .fo_trig_end(fo_trig_end)
);

// File: tb/tb_rail_frame_extractor.sv
`timescale 1ns/1ps
module tb_rail_frame_extractor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] level_thresh = 12'h800;
  logic smp_valid = 1'b0;
  logic [11:0] smp_data = 12'h000;
  logic link_up, fo_valid, fo_sof, fo_eof, fo_err, fo_trig_end;
  logic [11:0] fo_data;
  logic [6:0] fo_chan;
  logic [7:0] fo_addr;
  logic [2:0] fo_frame;

  always #2.5 clk = ~clk;

  rail_frame_extractor dut (.*);

  localparam logic [11:0] HI = 12'hE00, LO = 12'h100;

  int checks = 0, fails = 0, beats = 0;
  bit done = 1'b0;
  logic [33:0] q[$];
  int exp_frame = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11: junk between strobes
  task automatic smp(input logic [11:0] v);
    @(negedge clk); smp_valid = 1'b1; smp_data = v;
    @(negedge clk); smp_valid = 1'b0; smp_data = 12'hFFF;
    @(negedge clk);
  endtask

  task automatic lows(input int n);
    for (int i = 0; i < n; i++) smp(LO);
  endtask

  task automatic frame(input logic [7:0] addr, input bit err, input logic [11:0] one,
                       input logic [11:0] zero, input int seed, input bit expect_out, input bit flat);
    repeat (3) smp(one);
    for (int i = 7; i >= 0; i--) smp(addr[i] ? one : zero);
    smp(err ? one : zero);
    for (int c = 0; c < 128; c++) begin
      logic [11:0] v;
      v = flat ? zero : 12'((c * 37 + seed * 11) & 12'hFFF);
      if (expect_out)
        q.push_back({(c == 127 && exp_frame == 5), 3'(exp_frame), err, addr,
                     (c == 127), (c == 0), 7'(c), v});
      smp(v);
    end
    if (expect_out) exp_frame = (exp_frame + 1) % 6;
  endtask

  // scoreboard monitor: R5 R6 R7 R8 R9
  always @(negedge clk) begin
    if (rst_n && fo_valid) begin
      logic [33:0] act;
      beats++;
      act = {fo_trig_end, fo_frame, fo_err, fo_addr, fo_eof, fo_sof, fo_chan, fo_data};
      if (q.size() == 0) chk(1'b0, "R10 unexpected beat", int'(act[31:0]), 0);
      else begin
        logic [33:0] e;
        e = q.pop_front();
        chk(act == e, "R5/R6/R7/R9 beat", int'(act[31:0]), int'(e[31:0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(link_up == 1'b0, "R1 link_up", link_up, 0);
    chk(fo_valid == 1'b0, "R1 fo_valid", fo_valid, 0);
    rst_n = 1'b1;
    // R2: wrong spacing then correct spacing
    smp(HI); lows(29); smp(HI);
    chk(link_up == 1'b0, "R2 spacing 30", link_up, 0);
    lows(34); smp(HI);
    chk(link_up == 1'b1, "R2 spacing 35", link_up, 1);
    lows(5);
    // R8 back-to-back six frames, R3 threshold edge on frame 1
    frame(8'hA5, 1'b0, HI, LO, 1, 1'b1, 1'b0);
    frame(8'h3C, 1'b1, 12'h801, 12'h800, 2, 1'b1, 1'b0);
    frame(8'h81, 1'b0, HI, LO, 3, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, HI, LO, 4, 1'b1, 1'b0);
    frame(8'h00, 1'b0, HI, LO, 5, 1'b1, 1'b0);
    frame(8'h5A, 1'b1, HI, LO, 6, 1'b1, 1'b0);
    chk(q.size() == 0, "R9 six frames drained", q.size(), 0);
    lows(34); smp(HI); lows(34); smp(HI);
    chk(link_up == 1'b1, "R2 sync kept", link_up, 1);
    lows(3);
    frame(8'h12, 1'b0, HI, LO, 7, 1'b1, 1'b0);   // R9 wrap to 0
    // R4 timeout
    smp(HI); lows(39);
    chk(link_up == 1'b1, "R4 before timeout", link_up, 1);
    lows(1);
    chk(link_up == 1'b0, "R4 timeout", link_up, 0);
    exp_frame = 0;
    // R10 ignored while unlocked
    begin
      int b0;
      b0 = beats;
      frame(8'h00, 1'b0, HI, LO, 0, 1'b0, 1'b1);
      chk(beats == b0, "R10 no beats unlocked", beats - b0, 0);
    end
    smp(HI); lows(34); smp(HI);
    chk(link_up == 1'b1, "R2 relock", link_up, 1);
    lows(3);
    frame(8'hC3, 1'b1, HI, LO, 8, 1'b1, 1'b0);   // R4 index restarted at 0
    lows(10);
    chk(q.size() == 0, "R6 all beats seen", q.size(), 0);
    chk(beats == 8 * 128, "R6 beat count", beats, 8 * 128);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule